// File: doc/BRIEF.md
# Three-Phase Gate Drive Shaper with Dead Time and Pulse Deletion

This block sits between a three-phase PWM modulator and the gate drivers of an inverter bridge. For each phase it takes one raw PWM level and turns it into a top-switch drive and a bottom-switch drive. A raw level of 1 selects the top switch and a level of 0 selects the bottom switch. First it removes any high or low pulse that is shorter than a programmed minimum width. Then it inserts a programmed interval with both switches off at every change of the selected switch.

An emergency trip input shuts all six drives off two clock edges after it is sampled. The trip is latched and clears only through reset. The latch state is shown on a status output. While reset is asserted, all drives are held low. Minimum width and underlap are plain inputs, counted in clock cycles. They are meant to be changed only while reset is held.

Top module: `gate_shaper`

## Requirements
- R1: In every phase, the top drive and the bottom drive are never high in the same cycle, for any input sequence.
- R2: With an underlap of U ≥ 1, a switch-over leaves both drives of the phase low for exactly U cycles. If the raw level changes just before clock edge 1, the outgoing drive is still high after edges 1..W (minimum width W ≥ 1). Both drives are low after edges W+1..W+U, and the incoming drive is high after edge W+U+1.
- R3: With an underlap of 0, the bottom drive is the inverse of the top drive in every cycle once the first drive has come on after reset. The hand-over happens at a single clock edge.
- R4: A raw high pulse or raw low pulse that lasts fewer than W clock edges is deleted: the drives keep the state they had before the pulse.
- R5: A raw pulse of P ≥ W cycles is kept. The incoming drive of that pulse is high for P − U cycles, provided the raw level then stays back for at least W cycles.
- R6: A minimum width of 0 disables deletion. A one-cycle raw pulse reaches the drives one edge after it is sampled.
- R7: A trip request that is sampled high at one clock edge forces all six drives low, and drives the status output `trip_ok` low, after the next clock edge.
- R8: Once tripped, the drives stay low and `trip_ok` stays low after the trip request returns low, whatever the raw inputs do, until reset.
- R9: While `rst` is high, all six drives are low. After one clock edge in reset, the trip latch is clear and `trip_ok` is 1.
- R10: Phases are independent: activity on one raw input leaves the drives of the other phases unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also gates the drives low directly |
| raw_pwm | input | NPH | Raw PWM level per phase (1 = top switch wanted) |
| min_width | input | CNT_W | Minimum accepted pulse width in cycles, 0 disables deletion |
| underlap | input | CNT_W | Both-off interval in cycles at each switch-over |
| trip_req | input | 1 | Emergency trip request, active high |
| hi_drv | output | NPH | Top-switch gate drive per phase |
| lo_drv | output | NPH | Bottom-switch gate drive per phase |
| trip_ok | output | 1 | 1 while not tripped, 0 when the trip latch is set |

## Verification
The bench builds the block with three phases and 6-bit width and underlap inputs. It runs two operating points. The first is W = 3 and U = 2, where deletion of 2-cycle pulses, the exact both-off window and the narrowing of a kept 8-cycle pulse to 6 cycles can all be told apart. The second is W = 0 and U = 0, which exercises the pass-through of single-cycle pulses and the strictly complementary hand-over. The trip is applied while the bridge is driving, so that both its two-edge latency and its persistence across changing raw inputs can be seen at the ports.

// File: rtl/gate_shaper_pkg.sv
package gate_shaper_pkg;

    // one phase worth of gate drives
    typedef struct packed {
        logic top;
        logic bot;
    } gate_pair_t;

    localparam gate_pair_t PAIR_OFF = '{top: 1'b0, bot: 1'b0};

    // drive pair that conducts for a wanted level
    function automatic gate_pair_t pair_for(input logic want_top);
        gate_pair_t p;
        p.top = want_top;
        p.bot = ~want_top;
        return p;
    endfunction

endpackage

// File: rtl/pulse_filter.sv
module pulse_filter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw,
    input  logic [CNT_W-1:0] min_w,
    output logic             lvl
);
    localparam logic [CNT_W:0]   ONE_X = 1;
    localparam logic [CNT_W-1:0] STEP  = 1;

    logic [CNT_W-1:0] cnt;
    logic             reached;

    // raw has differed for cnt+1 consecutive edges including this one
    assign reached = ({1'b0, cnt} + ONE_X) >= {1'b0, min_w};

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl <= 1'b0;
            cnt <= '0;
        end else if (raw == lvl) begin
            cnt <= '0;
        end else if (reached) begin
            lvl <= raw;
            cnt <= '0;
        end else begin
            cnt <= cnt + STEP;
        end
    end

    // checker: every accepted level segment lasts at least min_w cycles
    logic             lvl_prev;
    logic [CNT_W-1:0] stable_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_prev   <= 1'b0;
            stable_run <= '0;
        end else begin
            lvl_prev <= lvl;
            if (lvl != lvl_prev)
                stable_run <= '0;
            else if (stable_run != '1)
                stable_run <= stable_run + STEP;
        end
    end

    assert_min_segment_R4: assert property (@(posedge clk) disable iff (rst)
        (lvl != lvl_prev) |-> (({1'b0, stable_run} + ONE_X) >= {1'b0, min_w}));

endmodule

// File: rtl/underlap_gen.sv
module underlap_gen
    import gate_shaper_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             want_top,
    input  logic [CNT_W-1:0] underlap,
    output gate_pair_t       drv
);
    localparam logic [CNT_W:0]   ONE_X = 1;
    localparam logic [CNT_W-1:0] STEP  = 1;

    logic [CNT_W-1:0] cnt;
    logic             settled;
    logic             any_on;
    logic             gap_done;

    assign settled  = want_top ? (drv.top & ~drv.bot) : (drv.bot & ~drv.top);
    assign any_on   = drv.top | drv.bot;
    assign gap_done = ({1'b0, cnt} + ONE_X) >= {1'b0, underlap};

    always_ff @(posedge clk) begin
        if (rst) begin
            drv <= PAIR_OFF;
            cnt <= '0;
        end else if (settled) begin
            cnt <= '0;
        end else if (any_on) begin
            // wrong switch conducts: hand over at once or open both
            drv <= (underlap == '0) ? pair_for(want_top) : PAIR_OFF;
            cnt <= '0;
        end else if (gap_done) begin
            drv <= pair_for(want_top);
            cnt <= '0;
        end else begin
            cnt <= cnt + STEP;
        end
    end

    // checker: length of the current both-off run
    logic [CNT_W-1:0] off_run;

    always_ff @(posedge clk) begin
        if (rst)
            off_run <= '0;
        else if (any_on)
            off_run <= '0;
        else if (off_run != '1)
            off_run <= off_run + STEP;
    end

    assert_pair_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
        !(drv.top && drv.bot));

    assert_gap_top_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(drv.top) |-> (off_run >= underlap));

    assert_gap_bot_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(drv.bot) |-> (off_run >= underlap));

endmodule

// File: rtl/trip_latch.sv
module trip_latch (
    input  logic clk,
    input  logic rst,
    input  logic trip_req,
    output logic tripped
);
    logic req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= 1'b0;
            tripped <= 1'b0;
        end else begin
            req_q   <= trip_req;
            tripped <= tripped | req_q;
        end
    end

    assert_trip_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        tripped |=> tripped);

endmodule

// File: rtl/gate_shaper.sv
module gate_shaper
    import gate_shaper_pkg::*;
#(
    parameter int NPH   = 3,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPH-1:0]   raw_pwm,
    input  logic [CNT_W-1:0] min_width,
    input  logic [CNT_W-1:0] underlap,
    input  logic             trip_req,
    output logic [NPH-1:0]   hi_drv,
    output logic [NPH-1:0]   lo_drv,
    output logic             trip_ok
);
    logic       tripped;
    logic       kill;
    gate_pair_t drv [NPH];

    trip_latch u_trip (
        .clk      (clk),
        .rst      (rst),
        .trip_req (trip_req),
        .tripped  (tripped)
    );

    assign kill    = tripped | rst;
    assign trip_ok = ~tripped;

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        logic lvl;

        pulse_filter #(.CNT_W(CNT_W)) u_filt (
            .clk   (clk),
            .rst   (rst),
            .raw   (raw_pwm[p]),
            .min_w (min_width),
            .lvl   (lvl)
        );

        underlap_gen #(.CNT_W(CNT_W)) u_gap (
            .clk      (clk),
            .rst      (rst),
            .want_top (lvl),
            .underlap (underlap),
            .drv      (drv[p])
        );

        assign hi_drv[p] = drv[p].top & ~kill;
        assign lo_drv[p] = drv[p].bot & ~kill;
    end

    assert_out_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
        (hi_drv & lo_drv) == '0);

    assert_trip_kills_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(trip_req, 2) && !$past(rst, 1) && !$past(rst, 2))
            |-> (hi_drv == '0 && lo_drv == '0 && !trip_ok));

endmodule

// File: tb/sim_gate_shaper.sv
module sim_gate_shaper;
    localparam int NPH   = 3;
    localparam int CNT_W = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NPH-1:0]   raw_pwm = '0;
    logic [CNT_W-1:0] min_width = '0;
    logic [CNT_W-1:0] underlap = '0;
    logic             trip_req = 1'b0;
    logic [NPH-1:0]   hi_drv;
    logic [NPH-1:0]   lo_drv;
    logic             trip_ok;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    gate_shaper #(.NPH(NPH), .CNT_W(CNT_W)) u0 (
        .clk       (clk),
        .rst       (rst),
        .raw_pwm   (raw_pwm),
        .min_width (min_width),
        .underlap  (underlap),
        .trip_req  (trip_req),
        .hi_drv    (hi_drv),
        .lo_drv    (lo_drv),
        .trip_ok   (trip_ok)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reset with new operating point, then let the bottoms settle
    task automatic t_reset(input int w, input int u);
        @(negedge clk);
        rst = 1'b1;
        raw_pwm = '0;
        trip_req = 1'b0;
        min_width = CNT_W'(w);
        underlap = CNT_W'(u);
        chk("R9 drives low in reset", {hi_drv, lo_drv}, 0);
        repeat (2) @(negedge clk);
        chk("R9 drives low in reset", {hi_drv, lo_drv}, 0);
        chk("R9 trip cleared", trip_ok, 1);
        rst = 1'b0;
        repeat (u + 3) @(negedge clk);
        chk("R1 bottoms on after reset", lo_drv, 3'b111);
        chk("R1 tops off after reset", hi_drv, 0);
    endtask

    // W=3 U=2: exact switch-over window on phase 0
    task automatic t_underlap();
        raw_pwm[0] = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (k <= 3)      chk("R2 outgoing still on", {hi_drv[0], lo_drv[0]}, 2'b01);
            else if (k <= 5) chk("R2 both off window", {hi_drv[0], lo_drv[0]}, 2'b00);
            else             chk("R2 incoming on", {hi_drv[0], lo_drv[0]}, 2'b10);
        end
        raw_pwm[0] = 1'b0;
        for (int k = 1; k <= 7; k++) begin
            @(negedge clk);
            if (k <= 3)      chk("R2 top still on", {hi_drv[0], lo_drv[0]}, 2'b10);
            else if (k <= 5) chk("R2 both off on return", {hi_drv[0], lo_drv[0]}, 2'b00);
            else             chk("R2 bottom back", {hi_drv[0], lo_drv[0]}, 2'b01);
        end
    endtask

    // W=3: 2-cycle pulses of either polarity vanish
    task automatic t_short();
        int bad;
        raw_pwm[0] = 1'b1;
        repeat (2) @(negedge clk);
        raw_pwm[0] = 1'b0;
        bad = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if ({hi_drv[0], lo_drv[0]} != 2'b01) bad++;
        end
        chk("R4 short high pulse deleted", bad, 0);
        raw_pwm[0] = 1'b1;
        repeat (10) @(negedge clk);
        chk("R4 top on before low pulse", {hi_drv[0], lo_drv[0]}, 2'b10);
        raw_pwm[0] = 1'b0;
        repeat (2) @(negedge clk);
        raw_pwm[0] = 1'b1;
        bad = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if ({hi_drv[0], lo_drv[0]} != 2'b10) bad++;
        end
        chk("R4 short low pulse deleted", bad, 0);
        raw_pwm[0] = 1'b0;
        repeat (12) @(negedge clk);
        chk("R4 bottom restored", {hi_drv[0], lo_drv[0]}, 2'b01);
    endtask

    // W=3 U=2: 8-cycle pulse kept, narrowed by the underlap
    task automatic t_long();
        int n_hi;
        int first;
        n_hi = 0;
        first = 0;
        raw_pwm[0] = 1'b1;
        for (int k = 1; k <= 25; k++) begin
            @(negedge clk);
            if (k == 8) raw_pwm[0] = 1'b0;
            if (hi_drv[0]) begin
                n_hi++;
                if (first == 0) first = k;
            end
        end
        chk("R5 kept pulse width P-U", n_hi, 6);
        chk("R5 kept pulse start", first, 6);
        chk("R5 bottom after pulse", {hi_drv[0], lo_drv[0]}, 2'b01);
    endtask

    // one phase switching leaves the others alone
    task automatic t_indep();
        raw_pwm[1] = 1'b1;
        repeat (8) @(negedge clk);
        chk("R10 only phase 1 top", hi_drv, 3'b010);
        chk("R10 other bottoms kept", lo_drv, 3'b101);
        raw_pwm[1] = 1'b0;
        repeat (10) @(negedge clk);
        chk("R10 phase 1 back", lo_drv, 3'b111);
    endtask

    // trip latency and latching
    task automatic t_trip();
        int bad;
        raw_pwm[2] = 1'b1;
        repeat (10) @(negedge clk);
        chk("R7 driving before trip", {hi_drv, lo_drv}, 6'b100_011);
        trip_req = 1'b1;
        @(negedge clk);
        trip_req = 1'b0;
        chk("R7 not yet tripped after one edge", trip_ok, 1);
        @(negedge clk);
        chk("R7 drives off after two edges", {hi_drv, lo_drv}, 0);
        chk("R7 status low", trip_ok, 0);
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            raw_pwm = NPH'(k);
            @(negedge clk);
            if ({hi_drv, lo_drv} != 0 || trip_ok) bad++;
        end
        chk("R8 trip held while inputs move", bad, 0);
    endtask

    // W=0 U=0: single-cycle pass, complementary hand-over
    task automatic t_zero();
        int bad;
        int n_hi;
        raw_pwm[0] = 1'b1;
        @(negedge clk);
        raw_pwm[0] = 1'b0;
        chk("R6 edge 1 still bottom", {hi_drv[0], lo_drv[0]}, 2'b01);
        @(negedge clk);
        chk("R6 single pulse reaches top", {hi_drv[0], lo_drv[0]}, 2'b10);
        @(negedge clk);
        chk("R6 back to bottom", {hi_drv[0], lo_drv[0]}, 2'b01);
        bad = 0;
        n_hi = 0;
        for (int k = 0; k < 16; k++) begin
            raw_pwm[2] = (k % 3) != 0;
            @(negedge clk);
            if (hi_drv[2] == lo_drv[2]) bad++;
            if (hi_drv[2]) n_hi++;
        end
        chk("R3 strictly complementary", bad, 0);
        chk("R3 top active in stream", n_hi > 0, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset(3, 2);
        t_underlap();
        t_short();
        t_long();
        t_indep();
        t_trip();
        t_reset(0, 0);
        t_zero();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule